// File: doc/BRIEF.md
# Program Address Sequencer with Circular Return Stack

This block produces the instruction fetch address for a small 8-bit processor whose instructions are 14 bits wide. It keeps a 13-bit program counter and an eight-entry return stack. Each clock it either holds the counter, advances it by one, or loads it from one of several sources. Those sources are a computed jump that writes the low byte from the ALU result, a literal jump or call carried in the opcode, a return popped from the stack, and the interrupt vector. The upper counter bits for computed and literal jumps come from a separate 5-bit holding value, and the two kinds of jump take different slices of it.

The return stack has no overflow or underflow indication and its pointer cannot be seen. When more than eight calls are nested, the newest entry overwrites the oldest one. A pop on an empty stack returns whatever stale entry sits below the pointer. Any load of the counter raises a one-cycle flush output, so the decoder can turn the instruction already fetched into a no-operation. The fetch address is the counter truncated to the implemented program space, which is 2K words by default or 1K words, so addresses above that space wrap around.

Top module: `prog_seq_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, fetch_addr is 0000h and flush is 0. Reset also clears the stack pointer and all eight stack entries to 0000h.
- R2: With step_en as the only strobe, the 13-bit counter increments modulo 2^13. fetch_addr always equals the counter's low IMPL_BITS bits zero-extended to 13 bits, so 07FFh steps to fetch address 0000h when IMPL_BITS = 11.
- R3: With low_wr as the highest active strobe, the counter becomes {hold_hi[4:0], alu_res[7:0]}.
- R4: With jump_en as the highest active strobe, the counter becomes {hold_hi[4:3], lit[10:0]}.
- R5: With call_en as the highest active strobe, the current 13-bit counter value is pushed and the counter loads as in R4.
- R6: With irq_en active, the current counter value is pushed and the counter becomes 0004h.
- R7: With ret_en as the highest active strobe, the counter is loaded with the most recently pushed entry, and the pointer steps back by one.
- R8: The stack holds 8 entries in a circular manner. After N > 8 pushes, the next 8 pops return pushes N down to N-7, and further pops return pushes N, N-1 and so on again.
- R9: A pop on an empty stack moves the modulo-8 pointer back and returns the stale entry stored there. Right after reset, that entry is 0000h.
- R10: Strobe priority is irq_en > call_en > jump_en > ret_en > low_wr > step_en. Lower strobes active in the same cycle have no effect. With no strobe active, the counter holds.
- R11: flush is 1 for exactly the cycle after any counter load (R3 to R7) and 0 after a step or a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the counter by one |
| low_wr | input | 1 | Computed jump: low byte written from the ALU result |
| jump_en | input | 1 | Literal jump |
| call_en | input | 1 | Literal call (push then jump) |
| ret_en | input | 1 | Return (pop) |
| irq_en | input | 1 | Interrupt vectoring (push then go to 0004h) |
| alu_res | input | 8 | ALU result for computed jumps |
| lit | input | 11 | Opcode literal target |
| hold_hi | input | 5 | Holding value for the upper counter bits |
| fetch_addr | output | 13 | Instruction fetch address |
| flush | output | 1 | Discard the already-fetched instruction |

## Verification
The bench nests ten calls and then unwinds them. A stack that saturated or flagged overflow, instead of wrapping, would return the wrong addresses on the ninth and tenth pops. It pops on an empty stack right after reset, which catches a pointer that clamps at zero or returns the vector instead of the cleared stale entry. Directed cases drive 07FFh through a step to show the wrap within the implemented space, and they mix the holding bits to catch a swapped slice between computed and literal jumps. Random strobe combinations run against a bench model and expose any priority inversion or a flush that is missing or lasts too long.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
    localparam int PC_W    = 13;
    localparam int HOLD_W  = 5;
    localparam int LIT_W   = 11;
    localparam int DATA_W  = 8;
    localparam int DEPTH   = 8;
    localparam logic [PC_W-1:0] IRQ_VEC = 13'h0004;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [HOLD_W-1:0] hold_t;
    typedef logic [LIT_W-1:0]  lit_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [2:0] {
        OP_HOLD, OP_STEP, OP_LOW, OP_JUMP, OP_CALL, OP_RET, OP_IRQ
    } pc_op_e;

    typedef struct packed {
        logic irq;
        logic call;
        logic jump;
        logic ret;
        logic low;
        logic step;
    } strobe_t;

    typedef struct packed {
        pc_t  nxt;
        logic push;
        logic pop;
        logic taken;
    } pc_ctl_t;

    function automatic pc_op_e pick_op(strobe_t s);
        if (s.irq)       return OP_IRQ;
        else if (s.call) return OP_CALL;
        else if (s.jump) return OP_JUMP;
        else if (s.ret)  return OP_RET;
        else if (s.low)  return OP_LOW;
        else if (s.step) return OP_STEP;
        return OP_HOLD;
    endfunction

    function automatic pc_t low_target(hold_t h, data_t d);
        return {h, d};
    endfunction

    function automatic pc_t lit_target(hold_t h, lit_t l);
        return {h[HOLD_W-1:HOLD_W-2], l};
    endfunction
endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import prog_seq_pkg::*;
(
    input  pc_op_e  op,
    input  pc_t     pc,
    input  data_t   alu_res,
    input  lit_t    lit,
    input  hold_t   hold_hi,
    input  pc_t     tos,
    output pc_ctl_t ctl
);
    always_comb begin
        ctl = '{nxt: pc, push: 1'b0, pop: 1'b0, taken: 1'b0};
        unique case (op)
            OP_STEP: ctl.nxt = pc + 1'b1;
            OP_LOW: begin
                ctl.nxt   = low_target(hold_hi, alu_res);
                ctl.taken = 1'b1;
            end
            OP_JUMP: begin
                ctl.nxt   = lit_target(hold_hi, lit);
                ctl.taken = 1'b1;
            end
            OP_CALL: begin
                ctl.nxt   = lit_target(hold_hi, lit);
                ctl.push  = 1'b1;
                ctl.taken = 1'b1;
            end
            OP_RET: begin
                ctl.nxt   = tos;
                ctl.pop   = 1'b1;
                ctl.taken = 1'b1;
            end
            OP_IRQ: begin
                ctl.nxt   = IRQ_VEC;
                ctl.push  = 1'b1;
                ctl.taken = 1'b1;
            end
            default: ctl.nxt = pc;
        endcase
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import prog_seq_pkg::*;
#(
    parameter int ENTRIES = DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  pc_t  push_val,
    output pc_t  tos
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] below;
    pc_t              slot [ENTRIES];

    assign below = sp - 1'b1;
    assign tos   = slot[below];

    always_ff @(posedge clk) begin
        if (rst)       sp <= '0;
        else if (push) sp <= sp + 1'b1;
        else if (pop)  sp <= below;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (push && (sp == PTR_W'(i)))
                slot[i] <= push_val;
        end
    end
endmodule

// File: rtl/prog_seq_unit.sv
module prog_seq_unit
    import prog_seq_pkg::*;
#(
    parameter int IMPL_BITS = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step_en,
    input  logic        low_wr,
    input  logic        jump_en,
    input  logic        call_en,
    input  logic        ret_en,
    input  logic        irq_en,
    input  logic [7:0]  alu_res,
    input  logic [10:0] lit,
    input  logic [4:0]  hold_hi,
    output logic [12:0] fetch_addr,
    output logic        flush
);
    localparam int PAD_W = PC_W - IMPL_BITS;

    pc_t     pc;
    pc_t     tos;
    strobe_t strb;
    pc_op_e  op;
    pc_ctl_t ctl;

    assign strb = '{irq: irq_en, call: call_en, jump: jump_en,
                    ret: ret_en, low: low_wr, step: step_en};
    assign op   = pick_op(strb);

    pc_next_sel u_sel (
        .op      (op),
        .pc      (pc),
        .alu_res (alu_res),
        .lit     (lit),
        .hold_hi (hold_hi),
        .tos     (tos),
        .ctl     (ctl)
    );

    ret_stack #(.ENTRIES(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (ctl.push),
        .pop      (ctl.pop),
        .push_val (pc),
        .tos      (tos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            flush <= 1'b0;
        end else begin
            pc    <= ctl.nxt;
            flush <= ctl.taken;
        end
    end

    if (PAD_W > 0) begin : g_trunc
        assign fetch_addr = {{PAD_W{1'b0}}, pc[IMPL_BITS-1:0]};
    end else begin : g_full
        assign fetch_addr = pc;
    end
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
    parameter int IMPL_BITS = 11
) (
    input logic        clk,
    input logic        rst,
    input logic        step_en,
    input logic        low_wr,
    input logic        jump_en,
    input logic        call_en,
    input logic        ret_en,
    input logic        irq_en,
    input logic [7:0]  alu_res,
    input logic [10:0] lit,
    input logic [4:0]  hold_hi,
    input logic [12:0] fetch_addr,
    input logic        flush
);
    localparam logic [12:0] MASK = 13'((1 << IMPL_BITS) - 1);

    logic any_load;
    assign any_load = irq_en | call_en | jump_en | ret_en | low_wr;

    // R1
    reset_release_chk: assert property (@(posedge clk)
        $fell(rst) |-> (fetch_addr == 13'h0000) && !flush);

    // R2
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !any_load) |=> fetch_addr == ((($past(fetch_addr)) + 13'd1) & MASK));

    // R3
    low_write_chk: assert property (@(posedge clk) disable iff (rst)
        (low_wr && !(irq_en | call_en | jump_en | ret_en))
        |=> fetch_addr == ({$past(hold_hi), $past(alu_res)} & MASK));

    // R4
    lit_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (jump_en && !(irq_en | call_en))
        |=> fetch_addr == ({$past(hold_hi[4:3]), $past(lit)} & MASK));

    // R6
    irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
        irq_en |=> fetch_addr == 13'h0004);

    // R11
    flush_set_chk: assert property (@(posedge clk) disable iff (rst)
        any_load |=> flush);

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !any_load |=> !flush);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(any_load | step_en) |=> $stable(fetch_addr));
endmodule

bind prog_seq_unit prog_seq_chk #(.IMPL_BITS(IMPL_BITS)) u_chk (
    .clk(clk), .rst(rst), .step_en(step_en), .low_wr(low_wr),
    .jump_en(jump_en), .call_en(call_en), .ret_en(ret_en), .irq_en(irq_en),
    .alu_res(alu_res), .lit(lit), .hold_hi(hold_hi),
    .fetch_addr(fetch_addr), .flush(flush)
);

// File: tb/prog_seq_unit_test.sv
module prog_seq_unit_test;
    localparam int IMPL = 11;
    localparam logic [12:0] MASK = 13'((1 << IMPL) - 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 0, low_wr = 0, jump_en = 0, call_en = 0, ret_en = 0, irq_en = 0;
    logic [7:0]  alu_res = 0;
    logic [10:0] lit = 0;
    logic [4:0]  hold_hi = 0;
    logic [12:0] fetch_addr;
    logic        flush;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [12:0] m_pc;
    logic [12:0] m_stk [8];
    logic [2:0]  m_sp;
    logic        m_flush;

    always #2.5 clk = ~clk;

    prog_seq_unit #(.IMPL_BITS(IMPL)) uut (
        .clk(clk), .rst(rst), .step_en(step_en), .low_wr(low_wr),
        .jump_en(jump_en), .call_en(call_en), .ret_en(ret_en), .irq_en(irq_en),
        .alu_res(alu_res), .lit(lit), .hold_hi(hold_hi),
        .fetch_addr(fetch_addr), .flush(flush)
    );

    function automatic logic [12:0] exp_fetch(logic [12:0] p);
        return p & MASK;
    endfunction

    task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 0; m_sp = 0; m_flush = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = 0;
    endtask

    // Bench model of one clock from the requirements (R2..R10)
    task automatic model_step();
        logic [12:0] cur;
        cur = m_pc;
        m_flush = 1'b1;
        if (irq_en) begin
            m_stk[m_sp] = cur; m_sp = m_sp + 1; m_pc = 13'h0004;
        end else if (call_en) begin
            m_stk[m_sp] = cur; m_sp = m_sp + 1; m_pc = {hold_hi[4:3], lit};
        end else if (jump_en) begin
            m_pc = {hold_hi[4:3], lit};
        end else if (ret_en) begin
            m_sp = m_sp - 1; m_pc = m_stk[m_sp];
        end else if (low_wr) begin
            m_pc = {hold_hi, alu_res};
        end else begin
            m_flush = 1'b0;
            if (step_en) m_pc = m_pc + 1;
        end
    endtask

    task automatic drive(bit s, bit l, bit j, bit c, bit r, bit q,
                         logic [7:0] a, logic [10:0] li, logic [4:0] h);
        step_en = s; low_wr = l; jump_en = j; call_en = c; ret_en = r; irq_en = q;
        alu_res = a; lit = li; hold_hi = h;
        @(posedge clk);
        model_step();
        #1;
    endtask

    task automatic cyc(string tag, bit s, bit l, bit j, bit c, bit r, bit q,
                       logic [7:0] a, logic [10:0] li, logic [4:0] h);
        drive(s, l, j, c, r, q, a, li, h);
        check(tag, fetch_addr, exp_fetch(m_pc));
        check({tag, " flush R11"}, {12'd0, flush}, {12'd0, m_flush});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step_en = 0; low_wr = 0; jump_en = 0; call_en = 0; ret_en = 0; irq_en = 0;
        repeat (2) @(posedge clk);
        model_reset();
        #1;
        check("R1 reset addr", fetch_addr, 13'h0000);
        check("R1 reset flush", {12'd0, flush}, 13'd0);
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        do_reset();
        @(negedge clk);
        // R1: first cycle after release, idle
        cyc("R1 after release", 0,0,0,0,0,0, 0, 0, 0);
        // R9: pop on empty stack after reset returns cleared entry
        cyc("R2 step", 1,0,0,0,0,0, 0, 0, 0);
        cyc("R2 step", 1,0,0,0,0,0, 0, 0, 0);
        cyc("R9 empty pop", 0,0,0,0,1,0, 0, 0, 0);
        check("R9 empty pop zero", fetch_addr, 13'h0000);
        // R2 wrap in implemented space
        cyc("R4 jump", 0,0,1,0,0,0, 0, 11'h7FE, 5'b00111);
        check("R4 slice", fetch_addr, 13'h07FE);
        cyc("R2 step", 1,0,0,0,0,0, 0, 0, 0);
        cyc("R2 wrap", 1,0,0,0,0,0, 0, 0, 0);
        check("R2 wrap zero", fetch_addr, 13'h0000);
        // R3 computed jump uses all holding bits
        cyc("R3 low write", 0,1,0,0,0,0, 8'h3C, 11'h555, 5'h1A);
        check("R3 value", fetch_addr, 13'h023C);
        // R4 slice with upper holding bits set
        cyc("R4 jump hi", 0,0,1,0,0,0, 8'hFF, 11'h123, 5'b11000);
        check("R4 value", fetch_addr, 13'h0123);
        // R6 interrupt then R7 return
        cyc("R6 irq", 0,0,0,0,0,1, 0, 11'h456, 0);
        check("R6 vector", fetch_addr, 13'h0004);
        cyc("R7 return", 0,0,0,0,1,0, 0, 0, 0);
        check("R7 value", fetch_addr, 13'h0123);
        // R10 priority combinations
        cyc("R10 irq over call", 1,1,1,1,1,1, 8'h11, 11'h222, 5'h03);
        cyc("R10 call over jump", 1,1,1,1,1,0, 8'h11, 11'h333, 5'h03);
        cyc("R10 jump over ret", 1,1,1,0,1,0, 8'h11, 11'h044, 5'h03);
        cyc("R10 ret over low", 1,1,0,0,1,0, 8'h11, 0, 5'h03);
        cyc("R10 low over step", 1,1,0,0,0,0, 8'h77, 0, 5'h02);
        check("R10 low value", fetch_addr, 13'h0277);
        cyc("R10 hold", 0,0,0,0,0,0, 8'h00, 11'h7FF, 5'h1F);
        check("R10 hold value", fetch_addr, 13'h0277);
        // R5 / R8: ten nested calls then twelve returns
        do_reset();
        for (int i = 0; i < 10; i++) begin
            cyc("R5 call", 0,0,0,1,0,0, 0, 11'(16 * (i + 1)), 5'b01000);
            cyc("R2 step", 1,0,0,0,0,0, 0, 0, 0);
        end
        for (int i = 0; i < 12; i++) begin
            logic [12:0] want;
            int k;
            k = (i < 8) ? (10 - i) : (18 - i);
            want = (k == 1) ? 13'h0000 : 13'(16 * (k - 1) + 1);
            cyc("R8 return", 0,0,0,0,1,0, 0, 0, 0);
            check("R8 circular value", fetch_addr, want);
        end
        // Random mix against model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 64;
            cyc("R10 random", r[0], ($urandom % 6) == 0, ($urandom % 8) == 0,
                ($urandom % 7) == 0, ($urandom % 6) == 0, ($urandom % 20) == 0,
                8'($urandom), 11'($urandom), 5'($urandom));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule